// File: doc/BRIEF.md
# PLL Bring-Up Reset Sequencer

This block takes a clock-generating PLL from power-on to locked operation by stepping through three timed waits in a fixed order. First it holds the device in reset while the PLL regulators settle. Then it pulses the PLL reset for a minimum duration. Next it lets the loop acquire lock for a set number of reference-clock cycles. Only after all three waits does it move the clock path from bypass to the PLL output. The waits given in absolute time are converted into cycle counts of the free-running input clock, which is also the reference clock. Each conversion rounds up, so the clock can never make a wait shorter than its minimum.

A small word-addressed register port lets software start a re-lock and read the sequencer's progress. A re-lock goes back to the PLL-reset step and does not repeat the regulator settling wait. The analog PLL, the glitch-free mux and the divider programming sit outside this block. The block only drives their control lines: PLL reset, mode select and device-reset release. The register port is plain control: a write takes effect on the clock edge where `reg_wr` is high, and read data is combinational from `reg_addr`.

Top module: `pll_bringup_seq`

## Requirements
- R1: After `rst_n` is released, `dev_rst_n` stays low for exactly SETTLE_CYC = ceil(SETTLE_NS*1000 / CLK_PERIOD_PS) clock cycles. During that time `pll_rst` and `pll_sel` are both 0.
- R2: When the settling wait ends, `pll_rst` goes to 1 and stays there for exactly RST_CYC = ceil(RST_NS*1000 / CLK_PERIOD_PS) cycles. It then returns to 0.
- R3: After `pll_rst` falls, `pll_sel` stays 0 for exactly LOCK_CYCLES cycles, then rises.
- R4: `pll_sel` is 1 only in the locked state. It is never 1 while `pll_rst` is 1 or `dev_rst_n` is 0.
- R5: Word address 0 is the control register. Bit 0 is a re-lock command: writing 1 issues it, and the bit always reads 0. Bit 1 is a re-lock enable, which resets to 1 and is read/write. A write changes only bit 1, and all other bits read 0.
- R6: Word address 1 is read-only status with these bits:
  - bit 0: busy, which is 1 during any wait and 0 once PLL mode is selected
  - bit 1: `dev_rst_n`
  - bit 2: `pll_rst`
  - bit 3: `pll_sel`
  
  Writes to this address have no effect.
- R7: Word addresses 2 and 3 are reserved. They read 0, and writes to them change neither registers nor outputs.
- R8: A re-lock command in the locked state, with the stored enable at 1, acts at the next clock edge. It drops `pll_sel` to 0 and raises `pll_rst` for RST_CYC cycles, then runs the LOCK_CYCLES wait and selects PLL mode again. `dev_rst_n` stays 1 throughout.
- R9: A re-lock command that arrives while any wait is in progress is ignored. The running wait keeps its length.
- R10: A re-lock command is ignored while the stored enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| reg_addr | input | ADDR_W | Register word address |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| pll_rst | output | 1 | PLL reset control, 1 = held in reset |
| pll_sel | output | 1 | Clock mode select, 0 = bypass, 1 = PLL output |
| dev_rst_n | output | 1 | Device reset release, active low |

## Verification
The bench builds the block with a 4000 ps clock period, SETTLE_NS = 402, RST_NS = 102 and LOCK_CYCLES = 40. These values shrink the waits to 101, 26 and 40 cycles, so full power-up runs and repeated re-locks fit in a short run. Both time-based waits fall on fractional cycle counts, so the round-up rule of R1 and R2 is tested directly by the cycle-exact interval measurements. The defaults (25000, 250 and 2000 cycles) follow the same arithmetic.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [1:0] {
    ST_SETTLE = 2'd0,
    ST_PRST   = 2'd1,
    ST_LOCK   = 2'd2,
    ST_RUN    = 2'd3
  } seq_state_t;

  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_STAT = 1;

  // Cycles needed to cover t_ps at the given period, rounded up.
  function automatic int unsigned cycles_for(input longint unsigned t_ps,
                                             input longint unsigned period_ps);
    return 32'((t_ps + period_ps - 1) / period_ps);
  endfunction
endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int SETTLE_CYC = 100,
  parameter int RST_CYC    = 10,
  parameter int LOCK_CYC   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             relock,
  input  logic [CNT_W-1:0] cnt,
  output logic             clr,
  output seq_state_t       state
);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] RST_LAST    = CNT_W'(RST_CYC - 1);
  localparam logic [CNT_W-1:0] LOCK_LAST   = CNT_W'(LOCK_CYC - 1);

  seq_state_t nxt;

  always_comb begin
    nxt = state;
    clr = 1'b0;
    unique case (state)
      ST_SETTLE: if (cnt == SETTLE_LAST) begin nxt = ST_PRST; clr = 1'b1; end
      ST_PRST:   if (cnt == RST_LAST)    begin nxt = ST_LOCK; clr = 1'b1; end
      ST_LOCK:   if (cnt == LOCK_LAST)   begin nxt = ST_RUN;  clr = 1'b1; end
      ST_RUN: begin
        clr = 1'b1;
        if (relock) nxt = ST_PRST;
      end
      default: begin nxt = ST_SETTLE; clr = 1'b1; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_SETTLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/pll_seq_regs.sv
module pll_seq_regs
  import pll_seq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  seq_state_t        state,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              relock
);
  logic relock_en;
  logic ctrl_wr;
  logic unused_wbits;

  assign ctrl_wr      = reg_wr && (reg_addr == ADDR_W'(REG_CTRL));
  assign relock       = ctrl_wr && reg_wdata[0] && relock_en;
  assign unused_wbits = ^reg_wdata[DATA_W-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       relock_en <= 1'b1;
    else if (ctrl_wr) relock_en <= reg_wdata[1];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(REG_CTRL)) begin
      reg_rdata[1] = relock_en;
    end else if (reg_addr == ADDR_W'(REG_STAT)) begin
      reg_rdata[0] = (state != ST_RUN);
      reg_rdata[1] = (state != ST_SETTLE);
      reg_rdata[2] = (state == ST_PRST);
      reg_rdata[3] = (state == ST_RUN);
    end
  end
endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
  import pll_seq_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 4000,
  parameter int SETTLE_NS     = 100000,
  parameter int RST_NS        = 1000,
  parameter int LOCK_CYCLES   = 2000,
  parameter int ADDR_W        = 2,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pll_rst,
  output logic              pll_sel,
  output logic              dev_rst_n
);
  localparam int SETTLE_CYC = int'(cycles_for(longint'(SETTLE_NS) * 1000, longint'(CLK_PERIOD_PS)));
  localparam int RST_CYC    = int'(cycles_for(longint'(RST_NS) * 1000, longint'(CLK_PERIOD_PS)));
  localparam int LOCK_CYC   = LOCK_CYCLES;
  localparam int MAX_CYC    = (SETTLE_CYC > RST_CYC)
                              ? ((SETTLE_CYC > LOCK_CYC) ? SETTLE_CYC : LOCK_CYC)
                              : ((RST_CYC > LOCK_CYC) ? RST_CYC : LOCK_CYC);
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  seq_state_t       state;
  logic             clr;
  logic             relock;
  logic [CNT_W-1:0] cnt;

  pll_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cnt(cnt)
  );

  pll_seq_fsm #(
    .CNT_W(CNT_W), .SETTLE_CYC(SETTLE_CYC), .RST_CYC(RST_CYC), .LOCK_CYC(LOCK_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .relock(relock), .cnt(cnt), .clr(clr), .state(state)
  );

  pll_seq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .state(state), .reg_rdata(reg_rdata), .relock(relock)
  );

  assign pll_rst   = (state == ST_PRST);
  assign pll_sel   = (state == ST_RUN);
  assign dev_rst_n = (state != ST_SETTLE);
endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk #(
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 8,
  parameter int SETTLE_CYC = 100,
  parameter int RST_CYC    = 10,
  parameter int LOCK_CYC   = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              pll_rst,
  input logic              pll_sel,
  input logic              dev_rst_n
);
  int unsigned settle_len, rst_len, lock_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_len <= 0; rst_len <= 0; lock_len <= 0;
    end else begin
      settle_len <= !dev_rst_n ? settle_len + 1 : 0;
      rst_len    <= pll_rst ? rst_len + 1 : 0;
      lock_len   <= (dev_rst_n && !pll_rst && !pll_sel) ? lock_len + 1 : 0;
    end
  end

  AST_SETTLE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_rst_n) |-> settle_len >= SETTLE_CYC); // R1
  AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_rst_n |-> (!pll_rst && !pll_sel)); // R1
  AST_RST_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_rst) |-> rst_len >= RST_CYC); // R2
  AST_LOCK_WAIT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_sel) |-> lock_len >= LOCK_CYC); // R3
  AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pll_sel |-> (!pll_rst && dev_rst_n)); // R4
  AST_BUSY_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(1)) |-> (reg_rdata[0] == !pll_sel)); // R6
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr > ADDR_W'(1)) |-> (reg_rdata == '0)); // R7
  AST_NO_SETTLE_AGAIN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dev_rst_n) |-> dev_rst_n); // R8
endmodule

bind pll_bringup_seq pll_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .SETTLE_CYC(SETTLE_CYC), .RST_CYC(RST_CYC), .LOCK_CYC(LOCK_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .pll_rst(pll_rst), .pll_sel(pll_sel), .dev_rst_n(dev_rst_n)
);

// File: tb/sim_pll_bringup_seq.sv
module sim_pll_bringup_seq;
  localparam int P_PS     = 4000;
  localparam int P_SETTLE = 402;
  localparam int P_RST    = 102;
  localparam int P_LOCK   = 40;
  localparam int E_SETTLE = (P_SETTLE * 1000 + P_PS - 1) / P_PS; // 101
  localparam int E_RST    = (P_RST * 1000 + P_PS - 1) / P_PS;    // 26

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       pll_rst, pll_sel, dev_rst_n;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pll_bringup_seq #(
    .CLK_PERIOD_PS(P_PS), .SETTLE_NS(P_SETTLE), .RST_NS(P_RST),
    .LOCK_CYCLES(P_LOCK), .ADDR_W(2), .DATA_W(8)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pll_rst(pll_rst), .pll_sel(pll_sel), .dev_rst_n(dev_rst_n)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    reg_addr = a;
    #1;
    d = int'(reg_rdata);
  endtask

  // Called at a negedge: counts cycles of the pll_rst pulse, then of the lock wait.
  task automatic measure_relock(input string req, input bit poke);
    int n, bad, st;
    n = 0; bad = 0;
    while (pll_rst && n < 100000) begin
      n++;
      if (pll_sel || !dev_rst_n) bad++;
      @(negedge clk);
    end
    chk({req, "/R2 reset pulse length"}, n, E_RST);
    n = 0;
    rd(2'd1, st);
    chk({req, "/R6 busy during lock wait"}, st & 1, 1);
    while (!pll_sel && n < 100000) begin
      n++;
      if (pll_rst || !dev_rst_n) bad++;
      reg_wr = 1'b0;
      if (poke && n == 10) begin
        reg_addr = 2'd0; reg_wdata = 8'h03; reg_wr = 1'b1; // R9
      end
      @(negedge clk);
    end
    reg_wr = 1'b0;
    chk({req, "/R3 lock wait length (R9 poke ignored)"}, n, P_LOCK);
    chk({req, "/R4 R8 side signals during waits"}, bad, 0);
  endtask

  task automatic t_reset_state();
    int st;
    repeat (3) @(negedge clk);
    chk("R1 dev_rst_n in reset", int'(dev_rst_n), 0);
    chk("R4 pll_sel in reset", int'(pll_sel), 0);
    chk("R2 pll_rst in reset", int'(pll_rst), 0);
    rd(2'd1, st);
    chk("R6 status in reset", st, 1);
  endtask

  task automatic t_powerup();
    int n, bad, st;
    @(negedge clk);
    rst_n = 1'b1;
    n = 0; bad = 0;
    while (!dev_rst_n && n < 100000) begin
      n++;
      if (pll_rst || pll_sel) bad++;
      @(negedge clk);
    end
    chk("R1 settle length", n, E_SETTLE);
    chk("R1 quiet outputs during settle", bad, 0);
    measure_relock("powerup", 1'b1);
    rd(2'd1, st);
    chk("R6 status when locked", st, 8'h0A);
  endtask

  task automatic t_ctrl_rmw();
    int d;
    rd(2'd0, d);
    chk("R5 ctrl reset value", d, 8'h02);
    wr(2'd0, 8'hFC);
    rd(2'd0, d);
    chk("R5 only bit1 written", d, 8'h00);
    wr(2'd0, 8'h02);
    rd(2'd0, d);
    chk("R5 enable restored", d, 8'h02);
    chk("R5 outputs untouched", int'(pll_sel), 1);
  endtask

  task automatic t_status_ro();
    int d;
    wr(2'd1, 8'hFF);
    rd(2'd1, d);
    chk("R6 status write ignored", d, 8'h0A);
    rd(2'd0, d);
    chk("R6 ctrl untouched by status write", d, 8'h02);
  endtask

  task automatic t_reserved();
    int d;
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'hFF);
    rd(2'd2, d);
    chk("R7 reserved 2 reads zero", d, 0);
    rd(2'd3, d);
    chk("R7 reserved 3 reads zero", d, 0);
    rd(2'd0, d);
    chk("R7 ctrl untouched", d, 8'h02);
    chk("R7 pll_sel untouched", int'(pll_sel), 1);
  endtask

  task automatic t_relock_disabled();
    int bad;
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h01);
    bad = 0;
    repeat (20) begin
      if (!pll_sel || pll_rst) bad++;
      @(negedge clk);
    end
    chk("R10 disabled relock ignored", bad, 0);
    wr(2'd0, 8'h02);
    chk("R10 enable write alone no relock", int'(pll_sel), 1);
  endtask

  task automatic t_relock();
    int d;
    wr(2'd0, 8'h03);
    chk("R8 pll_sel drops at once", int'(pll_sel), 0);
    chk("R8 pll_rst rises at once", int'(pll_rst), 1);
    measure_relock("R8 relock", 1'b0);
    rd(2'd0, d);
    chk("R5 relock bit reads zero", d, 8'h02);
    wr(2'd0, 8'h03);
    measure_relock("R8 second relock", 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset_state();
    t_powerup();
    t_ctrl_rmw();
    t_status_ro();
    t_reserved();
    t_relock_disabled();
    t_relock();
    finish_run();
  end
endmodule